// File: doc/BRIEF.md
# Pulsewidth Loop Controller

This block is the digital heart of a clock duty-cycle control loop. An external delay-line sampler reports the current pulse width as a 32-bit thermometer word: the run of ones starting at bit 0, taken as a fraction of the word width, is the measured duty cycle. Software or a fixed configuration supplies a target word in the same format. The controller compares the two words and filters the resulting up/down decisions. It then steers a segmented delay modulator through three sets of control codes: a bank of stretch stages, a bank of trim stages, and a fine stage.

Internally the loop holds one signed position in fine-step units. The position splits into a coarse part and a fine remainder in the range 0..2. A positive coarse part fills the stretch stages one after another, and a negative coarse part fills the trim stages, so the two banks never work against each other. Decisions are taken only on a divided loop tick, which leaves the filter path several clocks to settle. A lock detector freezes the position once the measurement has matched the target for long enough.

Top module: `pwl_ctrl`

## Requirements
- R1: While reset is asserted and right after it, every stretch, trim and fine code is zero and `locked` is low.
- R2: The comparison counts the ones in each word and ignores their bit positions. The decision is up when the measured count is below the target count, down when it is above, and hold when the counts are equal.
- R3: The loop position changes only on a loop tick. Counting from reset release, the tick falls on every DIV_M-th clock.
- R4: The position moves one fine step in the decided direction after FILT_TH consecutive agreeing decisions. A hold decision, or a decision in the other direction, restarts the count.
- R5: The position saturates at +45 and -45 fine steps, and further decisions toward the limit leave it there.
- R6: With position P = 3*c + f and f in 0..2, `fine_code` carries f. For c > 0, stretch stage k (code bits [2k+1:2k]) carries c-3k clamped to 0..3 and every trim stage is 0. For c < 0 the trim stages are filled the same way with -c, and every stretch stage is 0.
- R7: `locked` rises after LOCK_N consecutive equal decisions, and not earlier.
- R8: While `locked` is high the position does not change. After lock is lost, tracking resumes.
- R9: `locked` falls after UNLOCK_N consecutive mismatching decisions. A single mismatch followed by a match keeps the lock.
- R10: A change of the target word clears `locked` at the next clock edge and restarts the lock count.
- R11: In a closed loop, the position settles at the first position along its path where the measured count equals the target count, and the loop locks there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meas_word | input | MEAS_W | Measured pulse width, thermometer coded |
| prog_word | input | MEAS_W | Target pulse width, thermometer coded |
| amp_code | output | N_STG*2 | Stretch stage settings, 2 bits per stage, stage 0 in the low bits |
| shr_code | output | N_STG*2 | Trim stage settings, 2 bits per stage, stage 0 in the low bits |
| fine_code | output | 2 | Fine stage setting, 0..2 |
| locked | output | 1 | Loop is locked and the position is frozen |

## Verification
The bench builds the block with DIV_M = 2 and keeps every other parameter at its default: 32-bit words, five stages per bank, three fine steps, a run length of 4, lock after 8 matches, unlock after 2 mismatches. With the short divider, every one of the 91 positions can be walked upward and downward, checking the stage codes at each position against their arithmetic decomposition, and each step can be timed to the exact clock. The remaining time covers filter rejection, bubbled measurement words, the lock and unlock counts, and two closed-loop settling runs against a behavioural sampler model.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

   // loop decision produced by the word comparator
   typedef enum logic [1:0] {
      DEC_HOLD = 2'd0,
      DEC_UP   = 2'd1,
      DEC_DN   = 2'd2
   } dec_e;

endpackage

// File: rtl/pwl_tick.sv
module pwl_tick #(
   parameter int DIV_M = 8
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);

   generate
      if (DIV_M == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV_M);
         logic [CW-1:0] cnt_q;

         assign tick = (cnt_q == CW'(DIV_M - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= cnt_q + CW'(1);
         end

         a_r3_tick_wraps: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/pwl_compare.sv
module pwl_compare #(
   parameter int MEAS_W = 32
) (
   input  logic [MEAS_W-1:0] meas_word,
   input  logic [MEAS_W-1:0] tgt_word,
   output pwl_pkg::dec_e     dec,
   output logic              equal
);
   import pwl_pkg::*;

   localparam int CW = $clog2(MEAS_W + 1);

   logic [CW-1:0] n_meas;
   logic [CW-1:0] n_tgt;

   // population counts make the decision immune to stray bubbles
   always_comb begin
      n_meas = '0;
      n_tgt  = '0;
      for (int i = 0; i < MEAS_W; i++) begin
         n_meas = n_meas + CW'(meas_word[i]);
         n_tgt  = n_tgt  + CW'(tgt_word[i]);
      end
   end

   always_comb begin
      if (n_meas < n_tgt)      dec = DEC_UP;
      else if (n_meas > n_tgt) dec = DEC_DN;
      else                     dec = DEC_HOLD;
      equal = (n_meas == n_tgt);
   end

   always_comb begin
      a_r2_hold_iff_equal: assert ((dec == DEC_HOLD) == equal);
   end

endmodule

// File: rtl/pwl_lock.sv
module pwl_lock #(
   parameter int LOCK_N   = 8,
   parameter int UNLOCK_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic equal,
   input  logic tgt_chg,
   output logic locked
);

   localparam int EW = $clog2(LOCK_N + 1);
   localparam int NW = $clog2(UNLOCK_N + 1);

   logic [EW-1:0] eq_cnt_q;
   logic [NW-1:0] ne_cnt_q;
   logic          locked_q;

   assign locked = locked_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         eq_cnt_q <= '0;
         ne_cnt_q <= '0;
      end else if (tgt_chg) begin
         locked_q <= 1'b0;
         eq_cnt_q <= '0;
         ne_cnt_q <= '0;
      end else if (tick) begin
         if (!locked_q) begin
            ne_cnt_q <= '0;
            if (!equal) begin
               eq_cnt_q <= '0;
            end else if (eq_cnt_q == EW'(LOCK_N - 1)) begin
               eq_cnt_q <= '0;
               locked_q <= 1'b1;
            end else begin
               eq_cnt_q <= eq_cnt_q + EW'(1);
            end
         end else begin
            eq_cnt_q <= '0;
            if (equal) begin
               ne_cnt_q <= '0;
            end else if (ne_cnt_q == NW'(UNLOCK_N - 1)) begin
               ne_cnt_q <= '0;
               locked_q <= 1'b0;
            end else begin
               ne_cnt_q <= ne_cnt_q + NW'(1);
            end
         end
      end
   end

   a_r7_lock_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_q) |-> $past(tick && equal && !tgt_chg));

   a_r9_unlock_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked_q) |-> $past(tgt_chg || (tick && !equal)));

   a_r10_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_chg |=> !locked_q);

endmodule

// File: rtl/pwl_filter.sv
module pwl_filter #(
   parameter int FILT_TH = 4,
   parameter int PMAX    = 45,
   parameter int PW      = 7
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 run_en,
   input  pwl_pkg::dec_e        dec,
   output logic signed [PW-1:0] pos
);
   import pwl_pkg::*;

   localparam int RW = $clog2(FILT_TH + 1);
   localparam logic signed [PW-1:0] P_HI = PMAX[PW-1:0];
   localparam logic signed [PW-1:0] P_LO = -P_HI;

   dec_e                 run_dir_q;
   logic [RW-1:0]        run_cnt_q;
   logic signed [PW-1:0] pos_q;

   assign pos = pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_dir_q <= DEC_HOLD;
         run_cnt_q <= '0;
         pos_q     <= '0;
      end else if (tick) begin
         if (!run_en || dec == DEC_HOLD) begin
            run_dir_q <= DEC_HOLD;
            run_cnt_q <= '0;
         end else if (dec != run_dir_q) begin
            run_dir_q <= dec;
            run_cnt_q <= RW'(1);
         end else if (run_cnt_q == RW'(FILT_TH - 1)) begin
            run_cnt_q <= '0;
            if (dec == DEC_UP && pos_q < P_HI)      pos_q <= pos_q + PW'(1);
            else if (dec == DEC_DN && pos_q > P_LO) pos_q <= pos_q - PW'(1);
         end else begin
            run_cnt_q <= run_cnt_q + RW'(1);
         end
      end
   end

   a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(pos_q));

   a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (pos_q <= P_HI) && (pos_q >= P_LO));

   a_r4_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + PW'(1))
               || (pos_q == $past(pos_q) - PW'(1)));

   a_r8_hold_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(pos_q));

endmodule

// File: rtl/pwl_encode.sv
module pwl_encode #(
   parameter int N_STG    = 5,
   parameter int STEP_MAX = 3,
   parameter int FINE_N   = 3,
   parameter int PW       = 7,
   parameter int SW       = 2,
   parameter int FW       = 2
) (
   input  logic signed [PW-1:0] pos,
   output logic [N_STG*SW-1:0]  amp_code,
   output logic [N_STG*SW-1:0]  shr_code,
   output logic [FW-1:0]        fine_code
);

   int coarse;
   int fine;

   function automatic logic [SW-1:0] lvl(input int v);
      if (v <= 0)             return '0;
      else if (v >= STEP_MAX) return SW'(STEP_MAX);
      else                    return SW'(v);
   endfunction

   // floor division keeps the fine remainder non-negative
   always_comb begin
      int p;
      p = int'(pos);
      if (p >= 0) coarse = p / FINE_N;
      else        coarse = -((-p + FINE_N - 1) / FINE_N);
      fine = p - coarse * FINE_N;
   end

   assign fine_code = FW'(fine);

   generate
      for (genvar g = 0; g < N_STG; g++) begin : g_stg
         assign amp_code[g*SW +: SW] = lvl(coarse - STEP_MAX * g);
         assign shr_code[g*SW +: SW] = lvl(-coarse - STEP_MAX * g);
      end
   endgenerate

endmodule

// File: rtl/pwl_ctrl.sv
module pwl_ctrl #(
   parameter int MEAS_W   = 32,
   parameter int N_STG    = 5,
   parameter int STEP_MAX = 3,
   parameter int FINE_N   = 3,
   parameter int DIV_M    = 8,
   parameter int FILT_TH  = 4,
   parameter int LOCK_N   = 8,
   parameter int UNLOCK_N = 2,
   localparam int SW      = $clog2(STEP_MAX + 1),
   localparam int FW      = $clog2(FINE_N)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [MEAS_W-1:0]    meas_word,
   input  logic [MEAS_W-1:0]    prog_word,
   output logic [N_STG*SW-1:0]  amp_code,
   output logic [N_STG*SW-1:0]  shr_code,
   output logic [FW-1:0]        fine_code,
   output logic                 locked
);
   import pwl_pkg::*;

   localparam int PMAX = N_STG * STEP_MAX * FINE_N;
   localparam int PW   = $clog2(PMAX + 1) + 1;

   generate
      if (DIV_M < 1)     begin : g_bad_div  $error("DIV_M must be at least 1");    end
      if (FILT_TH < 2)   begin : g_bad_th   $error("FILT_TH must be at least 2");  end
      if (FINE_N < 2)    begin : g_bad_fine $error("FINE_N must be at least 2");   end
      if (LOCK_N < 1)    begin : g_bad_lk   $error("LOCK_N must be at least 1");   end
      if (UNLOCK_N < 1)  begin : g_bad_ul   $error("UNLOCK_N must be at least 1"); end
      if (STEP_MAX < 1)  begin : g_bad_stp  $error("STEP_MAX must be at least 1"); end
   endgenerate

   logic                 tick;
   dec_e                 dec;
   logic                 equal;
   logic                 tgt_chg;
   logic [MEAS_W-1:0]    tgt_q;
   logic signed [PW-1:0] pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgt_q <= '0;
      else        tgt_q <= prog_word;
   end

   assign tgt_chg = (prog_word != tgt_q);

   pwl_tick #(.DIV_M(DIV_M)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   pwl_compare #(.MEAS_W(MEAS_W)) u_cmp (
      .meas_word (meas_word),
      .tgt_word  (prog_word),
      .dec       (dec),
      .equal     (equal)
   );

   pwl_lock #(.LOCK_N(LOCK_N), .UNLOCK_N(UNLOCK_N)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .equal   (equal),
      .tgt_chg (tgt_chg),
      .locked  (locked)
   );

   pwl_filter #(.FILT_TH(FILT_TH), .PMAX(PMAX), .PW(PW)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .run_en (!locked),
      .dec    (dec),
      .pos    (pos)
   );

   pwl_encode #(.N_STG(N_STG), .STEP_MAX(STEP_MAX), .FINE_N(FINE_N),
                .PW(PW), .SW(SW), .FW(FW)) u_enc (
      .pos       (pos),
      .amp_code  (amp_code),
      .shr_code  (shr_code),
      .fine_code (fine_code)
   );

   a_r6_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (|amp_code) |-> (shr_code == '0));

   a_r8_codes_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable({amp_code, shr_code, fine_code}));

   a_r6_fine_range: assert property (@(posedge clk) disable iff (!rst_n)
      int'(fine_code) < FINE_N);

endmodule

// File: tb/pwl_ctrl_tb.sv
module pwl_ctrl_tb;

   localparam int M   = 2;
   localparam int TH  = 4;
   localparam int LN  = 8;
   localparam int UN  = 2;
   localparam int NS  = 5;
   localparam int SM  = 3;
   localparam int FN  = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] meas_open;
   logic [31:0] meas_cl;
   logic        closed;
   logic [31:0] meas_word;
   logic [31:0] prog_word;
   logic [9:0]  amp_code;
   logic [9:0]  shr_code;
   logic [1:0]  fine_code;
   logic        locked;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   assign meas_word = closed ? meas_cl : meas_open;

   pwl_ctrl #(.DIV_M(M), .FILT_TH(TH), .LOCK_N(LN), .UNLOCK_N(UN)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .meas_word (meas_word),
      .prog_word (prog_word),
      .amp_code  (amp_code),
      .shr_code  (shr_code),
      .fine_code (fine_code),
      .locked    (locked)
   );

   function automatic logic [31:0] therm(input int n);
      if (n >= 32) return '1;
      if (n <= 0)  return '0;
      return (32'd1 << n) - 32'd1;
   endfunction

   function automatic int clampi(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   function automatic int dec_pos(input logic [9:0] a, input logic [9:0] s, input logic [1:0] f);
      int net;
      net = 0;
      for (int i = 0; i < NS; i++) net += int'(a[2*i +: 2]) - int'(s[2*i +: 2]);
      return net * FN + int'(f);
   endfunction

   // behavioural sampler model: position 0 reads 16 ones, 3 fine steps per one
   always @(negedge clk)
      meas_cl <= therm(clampi((dec_pos(amp_code, shr_code, fine_code) + 48) / 3, 0, 32));

   task automatic check_pos(input int p, input string req);
      int c, f;
      logic [9:0] ea, es;
      c = (p >= 0) ? p / FN : -((-p + FN - 1) / FN);
      f = p - c * FN;
      for (int i = 0; i < NS; i++) begin
         ea[2*i +: 2] = 2'(clampi(c - SM * i, 0, SM));
         es[2*i +: 2] = 2'(clampi(-c - SM * i, 0, SM));
      end
      checks++;
      if (amp_code !== ea || shr_code !== es || fine_code !== 2'(f)) begin
         errors++;
         $display("FAIL %s pos %0d: amp %h shr %h fine %0d, expected amp %h shr %h fine %0d",
                  req, p, amp_code, shr_code, fine_code, ea, es, f);
      end
   endtask

   task automatic check_lock(input logic exp, input string req);
      checks++;
      if (locked !== exp) begin
         errors++;
         $display("FAIL %s locked %b expected %b", req, locked, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n * M) @(negedge clk);
   endtask

   task automatic wait_lock(input int exp_pos, input string req);
      int n;
      n = 0;
      repeat (M) @(negedge clk);
      while (!locked && n < 4000) begin
         @(negedge clk);
         n++;
      end
      check_lock(1'b1, req);
      check_pos(exp_pos, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] bub;
      rst_n     = 1'b0;
      closed    = 1'b0;
      prog_word = therm(32);
      meas_open = therm(0);
      repeat (3) @(negedge clk);
      // R1: reset state
      check_pos(0, "R1");
      check_lock(1'b0, "R1");
      rst_n = 1'b1;

      // R3 R4 R6: upward sweep, step lands on the last clock of each run
      for (int k = 1; k <= 45; k++) begin
         repeat (TH * M - 1) @(negedge clk);
         check_pos(k - 1, "R3");
         @(negedge clk);
         check_pos(k, "R6");
      end
      // R5: upper saturation
      ticks(3 * TH);
      check_pos(45, "R5");

      // R2 R6: downward sweep (measured above target)
      meas_open = therm(32);
      prog_word = therm(0);
      for (int k = 44; k >= -45; k--) begin
         repeat (TH * M - 1) @(negedge clk);
         check_pos(k + 1, "R3");
         @(negedge clk);
         check_pos(k, "R6");
      end
      ticks(3 * TH);
      check_pos(-45, "R5");

      // R4: one clean run up
      prog_word = therm(16);
      meas_open = therm(8);
      ticks(TH);
      check_pos(-44, "R4");
      // R4: alternating short runs are rejected
      for (int r = 0; r < 3; r++) begin
         meas_open = therm(8);
         ticks(TH - 1);
         meas_open = therm(24);
         ticks(TH - 1);
      end
      check_pos(-44, "R4");
      // R4: a hold decision restarts the run
      meas_open = therm(8);
      ticks(TH - 1);
      meas_open = therm(16);
      ticks(1);
      meas_open = therm(8);
      ticks(TH - 1);
      check_pos(-44, "R4");
      meas_open = therm(16);
      ticks(1);
      meas_open = therm(8);
      repeat (TH * M - 1) @(negedge clk);
      check_pos(-44, "R4");
      @(negedge clk);
      check_pos(-43, "R4");

      // R2 R7: bubbled word with equal ones count locks after LN matches
      bub = therm(16);
      bub[15] = 1'b0;
      bub[20] = 1'b1;
      meas_open = bub;
      ticks(LN - 1);
      check_lock(1'b0, "R7");
      ticks(1);
      check_lock(1'b1, "R2");
      check_pos(-43, "R7");

      // R8 R9: single mismatches keep lock, position frozen
      meas_open = therm(24);
      ticks(1);
      check_lock(1'b1, "R9");
      check_pos(-43, "R8");
      meas_open = bub;
      ticks(1);
      check_lock(1'b1, "R9");
      meas_open = therm(24);
      ticks(UN - 1);
      check_lock(1'b1, "R9");
      ticks(1);
      check_lock(1'b0, "R9");
      check_pos(-43, "R8");
      repeat (TH * M - 1) @(negedge clk);
      check_pos(-43, "R8");
      @(negedge clk);
      check_pos(-44, "R8");

      // R10: target change drops lock at once, relock counts afresh
      meas_open = therm(16);
      ticks(LN);
      check_lock(1'b1, "R7");
      prog_word = therm(20);
      meas_open = therm(20);
      @(negedge clk);
      check_lock(1'b0, "R10");
      repeat ((LN - 1) * M - 1) @(negedge clk);
      check_lock(1'b0, "R10");
      ticks(1);
      check_lock(1'b1, "R10");
      check_pos(-44, "R10");

      // R11: closed loop settles upward then downward
      closed    = 1'b1;
      prog_word = therm(21);
      wait_lock(15, "R11");
      prog_word = therm(8);
      wait_lock(-22, "R11");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule